// File: doc/BRIEF.md
# Segment Page Permission and Fault Classifier

This block decides, for one memory access of a 32-bit segmented memory management unit, which rights the access holds and whether it faults. A request carries the access kind (load, store or instruction fetch), the privilege state, whether instruction or data translation is enabled, the effective address, the outcome of a page-table lookup (hit or miss) and the two protection bits of the matching page entry. The top bits of the effective address pick one of sixteen segment attribute nibbles. Each nibble holds a user key, a supervisor key, a no-execute bit and a direct-store bit.

One cycle after each request the block returns the granted read, write and execute rights, a fault flag, the fault class (instruction or data), a 32-bit status word naming the cause and direction, the address to capture on a data fault, and a flag that marks an untranslated pass-through. The page walk and the translation cache fill sit outside this block. The lookup result arrives as an input.

Top module: `seg_perm_classifier`

## Requirements
- R1: The segment is chosen by effective address bits [31:28]. Its attribute nibble sits at `seg_attr[4*s+3:4*s]`, laid out as bit 0 user key, bit 1 supervisor key, bit 2 no-execute, bit 3 direct-store. The active key is the user key when `req_user` is 1 and the supervisor key otherwise.
- R2: With key 0, protection value 3 grants read only, and values 0, 1 and 2 grant read and write.
- R3: With key 1, protection value 0 grants nothing, values 1 and 3 grant read only, and value 2 grants read and write.
- R4: On the translated page path, execute is granted exactly when the segment no-execute bit is clear, whatever the protection value.
- R5: Access code 0 is a load, 1 a store, 2 a fetch, and 3 is treated as a load. A fetch with `req_ixlate`=0, or a load or store with `req_dxlate`=0, passes with read, write and execute all granted, `rsp_bypass`=1 and no fault. The segment, lookup and protection inputs are then ignored.
- R6: A translated, non-direct-store access whose lookup missed faults with status 0x40000000 for a load or fetch and 0x42000000 for a store.
- R7: A data access that lacks the right it needs faults with status 0x08000000 for a load and 0x0A000000 for a store. On any fault all three rights read 0 and `rsp_bypass` is 0. On a pass the status is 0.
- R8: A translated fetch from a no-execute or a direct-store segment faults with status 0x10000000. This check comes before the lookup result is used.
- R9: In a direct-store segment a data access ignores the lookup and protection inputs. A load passes only with key 0 and a store passes only with key 1. A passing access sets `rsp_bypass`=1 with rights read = not key, write = key, execute = 0. A refused access uses the R7 status codes.
- R10: `rsp_fault_instr` is 1 exactly for faults of fetches. `rsp_far` equals the request's effective address on a data fault and is 0 otherwise.
- R11: After reset every output is 0. `rsp_valid` is 1 in the cycle after a cycle with `req_valid`=1 and 0 otherwise. With no request, all other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_access | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| req_user | input | 1 | 1 when the processor is in user state |
| req_ixlate | input | 1 | Instruction translation enabled |
| req_dxlate | input | 1 | Data translation enabled |
| req_ea | input | 32 | Effective address |
| req_hit | input | 1 | Page-table lookup found an entry |
| req_pp | input | 2 | Protection bits of the found entry |
| seg_attr | input | 64 | Sixteen 4-bit segment attribute nibbles |
| rsp_valid | output | 1 | Result present |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |
| rsp_fault | output | 1 | Access faults |
| rsp_fault_instr | output | 1 | Fault is of the instruction class |
| rsp_bypass | output | 1 | Address passes untranslated |
| rsp_status | output | 32 | Fault status code, 0 on pass |
| rsp_far | output | 32 | Faulting address on a data fault, else 0 |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 4-bit segment selector, which gives sixteen segments. That size lets the test program seven distinct segments side by side: both keys clear, both keys set, user-only and supervisor-only keys, a no-execute segment, and two direct-store segments with opposite keys. With these segments the test can reach every row of both protection tables under both privilege states. It can also reach each fault cause in both directions and the ordering between real-mode bypass, the no-execute check and the lookup miss. Hold behaviour and the data fault address are covered by directed sequences.

// File: rtl/segperm_pkg.sv
package segperm_pkg;

    localparam int ATTR_W  = 4;
    localparam int ATTR_KU = 0;
    localparam int ATTR_KS = 1;
    localparam int ATTR_NX = 2;
    localparam int ATTR_DS = 3;

    localparam logic [31:0] ST_MISS   = 32'h4000_0000;
    localparam logic [31:0] ST_PROT   = 32'h0800_0000;
    localparam logic [31:0] ST_NOEXEC = 32'h1000_0000;
    localparam logic [31:0] ST_STORE  = 32'h0200_0000;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FC_NONE   = 2'd0,
        FC_MISS   = 2'd1,
        FC_PROT   = 2'd2,
        FC_NOEXEC = 2'd3
    } fcause_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

endpackage

// File: rtl/segperm_seg_pick.sv
module segperm_seg_pick
    import segperm_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SEL_W = 4
) (
    input  logic [AW-1:0]                  ea,
    input  logic [(1<<SEL_W)*ATTR_W-1:0]   seg_attr,
    input  logic                           user,
    output logic                           key,
    output logic                           no_exec,
    output logic                           dstore
);
    localparam int NUM_SEG = 1 << SEL_W;

    logic [ATTR_W-1:0] attr_arr [NUM_SEG];
    logic [ATTR_W-1:0] attr_sel;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_unpack
        assign attr_arr[g] = seg_attr[g*ATTR_W +: ATTR_W];
    end

    assign attr_sel = attr_arr[ea[AW-1 -: SEL_W]];
    assign key      = user ? attr_sel[ATTR_KU] : attr_sel[ATTR_KS];
    assign no_exec  = attr_sel[ATTR_NX];
    assign dstore   = attr_sel[ATTR_DS];
endmodule

// File: rtl/segperm_rights.sv
module segperm_rights
    import segperm_pkg::*;
(
    input  logic       key,
    input  logic [1:0] pp,
    input  logic       no_exec,
    output rights_t    rights
);
    always_comb begin
        rights.ex = ~no_exec;
        if (!key) begin
            rights.rd = 1'b1;
            rights.wr = (pp != 2'd3);
        end else begin
            rights.rd = (pp != 2'd0);
            rights.wr = (pp == 2'd2);
        end
    end
endmodule

// File: rtl/segperm_status.sv
module segperm_status
    import segperm_pkg::*;
(
    input  fcause_e     cause,
    input  logic        is_store,
    output logic [31:0] status
);
    always_comb begin
        unique case (cause)
            FC_MISS:   status = ST_MISS | (is_store ? ST_STORE : 32'h0);
            FC_PROT:   status = ST_PROT | (is_store ? ST_STORE : 32'h0);
            FC_NOEXEC: status = ST_NOEXEC;
            default:   status = 32'h0;
        endcase
    end
endmodule

// File: rtl/seg_perm_classifier.sv
module seg_perm_classifier
    import segperm_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SEL_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [1:0]                    req_access,
    input  logic                          req_user,
    input  logic                          req_ixlate,
    input  logic                          req_dxlate,
    input  logic [AW-1:0]                 req_ea,
    input  logic                          req_hit,
    input  logic [1:0]                    req_pp,
    input  logic [(1<<SEL_W)*ATTR_W-1:0]  seg_attr,
    output logic                          rsp_valid,
    output logic                          rsp_rd,
    output logic                          rsp_wr,
    output logic                          rsp_ex,
    output logic                          rsp_fault,
    output logic                          rsp_fault_instr,
    output logic                          rsp_bypass,
    output logic [31:0]                   rsp_status,
    output logic [AW-1:0]                 rsp_far
);
    typedef struct packed {
        logic          valid;
        rights_t       rights;
        logic          fault;
        logic          finstr;
        logic          bypass;
        logic [31:0]   status;
        logic [AW-1:0] far;
    } rsp_t;

    rsp_t    rsp_d, rsp_q;
    logic    seg_key, seg_nx, seg_ds;
    rights_t tbl_rights;
    fcause_e cause;
    logic    is_fetch, is_store, xlate_on, need_ok, ds_ok;
    logic [31:0] code;

    segperm_seg_pick #(.AW(AW), .SEL_W(SEL_W)) u_pick (
        .ea       (req_ea),
        .seg_attr (seg_attr),
        .user     (req_user),
        .key      (seg_key),
        .no_exec  (seg_nx),
        .dstore   (seg_ds)
    );

    segperm_rights u_rights (
        .key     (seg_key),
        .pp      (req_pp),
        .no_exec (seg_nx),
        .rights  (tbl_rights)
    );

    segperm_status u_status (
        .cause    (cause),
        .is_store (is_store),
        .status   (code)
    );

    assign is_fetch = (acc_e'(req_access) == ACC_FETCH);
    assign is_store = (acc_e'(req_access) == ACC_STORE);
    assign xlate_on = is_fetch ? req_ixlate : req_dxlate;
    assign ds_ok    = is_store ? seg_key : ~seg_key;

    always_comb begin
        unique case (1'b1)
            is_fetch: need_ok = tbl_rights.ex;
            is_store: need_ok = tbl_rights.wr;
            default:  need_ok = tbl_rights.rd;
        endcase
    end

    always_comb begin
        rsp_t    n;
        rights_t grant;
        logic    pass_thru;

        cause     = FC_NONE;
        grant     = '0;
        pass_thru = 1'b0;

        if (!xlate_on) begin
            grant     = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            pass_thru = 1'b1;
        end else if (is_fetch && (seg_nx || seg_ds)) begin
            cause = FC_NOEXEC;
        end else if (seg_ds) begin
            if (ds_ok) begin
                grant     = '{rd: ~seg_key, wr: seg_key, ex: 1'b0};
                pass_thru = 1'b1;
            end else begin
                cause = FC_PROT;
            end
        end else if (!req_hit) begin
            cause = FC_MISS;
        end else if (!need_ok) begin
            cause = FC_PROT;
        end else begin
            grant = tbl_rights;
        end

        n = rsp_q;
        if (req_valid) begin
            n.fault  = (cause != FC_NONE);
            n.finstr = n.fault && is_fetch;
            n.rights = n.fault ? '0 : grant;
            n.bypass = pass_thru;
            n.status = code;
            n.far    = (n.fault && !is_fetch) ? req_ea : '0;
        end
        n.valid = req_valid;
        rsp_d   = n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid       = rsp_q.valid;
    assign rsp_rd          = rsp_q.rights.rd;
    assign rsp_wr          = rsp_q.rights.wr;
    assign rsp_ex          = rsp_q.rights.ex;
    assign rsp_fault       = rsp_q.fault;
    assign rsp_fault_instr = rsp_q.finstr;
    assign rsp_bypass      = rsp_q.bypass;
    assign rsp_status      = rsp_q.status;
    assign rsp_far         = rsp_q.far;
endmodule

// File: rtl/segperm_checker.sv
module segperm_checker
    import segperm_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SEL_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic [1:0]                    req_access,
    input logic                          req_ixlate,
    input logic [AW-1:0]                 req_ea,
    input logic [(1<<SEL_W)*ATTR_W-1:0]  seg_attr,
    input logic                          rsp_valid,
    input logic                          rsp_rd,
    input logic                          rsp_wr,
    input logic                          rsp_ex,
    input logic                          rsp_fault,
    input logic                          rsp_fault_instr,
    input logic                          rsp_bypass,
    input logic [31:0]                   rsp_status,
    input logic [AW-1:0]                 rsp_far
);
    logic [ATTR_W-1:0] cur_attr;
    assign cur_attr = seg_attr[req_ea[AW-1 -: SEL_W]*ATTR_W +: ATTR_W];

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_status) && $stable(rsp_far) && $stable(rsp_fault)));

    // R7
    fault_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (!rsp_rd && !rsp_wr && !rsp_ex && !rsp_bypass && rsp_status != 32'h0));

    // R10
    class_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_instr |-> rsp_fault);

    // R10
    far_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((rsp_fault && !rsp_fault_instr) ? (rsp_far == $past(req_ea)) : (rsp_far == '0)));

    // R5
    real_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_access == 2'd2 && !req_ixlate)
        |=> (rsp_bypass && rsp_rd && rsp_wr && rsp_ex && !rsp_fault));

    // R8
    noexec_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_access == 2'd2 && req_ixlate && (cur_attr[ATTR_NX] || cur_attr[ATTR_DS]))
        |=> (rsp_fault && rsp_fault_instr && rsp_status == 32'h1000_0000));
endmodule

bind seg_perm_classifier segperm_checker #(.AW(AW), .SEL_W(SEL_W)) u_segperm_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_access      (req_access),
    .req_ixlate      (req_ixlate),
    .req_ea          (req_ea),
    .seg_attr        (seg_attr),
    .rsp_valid       (rsp_valid),
    .rsp_rd          (rsp_rd),
    .rsp_wr          (rsp_wr),
    .rsp_ex          (rsp_ex),
    .rsp_fault       (rsp_fault),
    .rsp_fault_instr (rsp_fault_instr),
    .rsp_bypass      (rsp_bypass),
    .rsp_status      (rsp_status),
    .rsp_far         (rsp_far)
);

// File: tb/seg_perm_classifier_bench.sv
module seg_perm_classifier_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int NVEC       = 29;

    typedef struct packed {
        logic [1:0]  acc;
        logic        usr;
        logic        ix;
        logic        dx;
        logic [3:0]  seg;
        logic        hit;
        logic [1:0]  pp;
        logic [5:0]  flags;   // rd wr ex fault instr bypass
        logic [31:0] status;
    } vec_t;

    localparam logic [49:0] VECS [NVEC] = '{
        {2'd0,1'b0,1'b1,1'b1,4'd0,1'b1,2'd3,6'b101000,32'h0000_0000}, // R2 R4
        {2'd1,1'b0,1'b1,1'b1,4'd0,1'b1,2'd3,6'b000100,32'h0A00_0000}, // R2 R7
        {2'd0,1'b0,1'b1,1'b1,4'd1,1'b1,2'd0,6'b000100,32'h0800_0000}, // R3 R7
        {2'd2,1'b0,1'b1,1'b1,4'd1,1'b1,2'd0,6'b001000,32'h0000_0000}, // R3 R4
        {2'd1,1'b0,1'b1,1'b1,4'd1,1'b1,2'd2,6'b111000,32'h0000_0000}, // R3
        {2'd1,1'b0,1'b1,1'b1,4'd1,1'b1,2'd1,6'b000100,32'h0A00_0000}, // R3 R7
        {2'd0,1'b1,1'b1,1'b1,4'd2,1'b1,2'd0,6'b000100,32'h0800_0000}, // R1 user key
        {2'd0,1'b0,1'b1,1'b1,4'd2,1'b1,2'd0,6'b111000,32'h0000_0000}, // R1 supervisor key
        {2'd0,1'b0,1'b1,1'b1,4'd6,1'b1,2'd0,6'b000100,32'h0800_0000}, // R1
        {2'd0,1'b1,1'b1,1'b1,4'd6,1'b1,2'd0,6'b111000,32'h0000_0000}, // R1
        {2'd1,1'b0,1'b1,1'b1,4'd0,1'b1,2'd1,6'b111000,32'h0000_0000}, // R2
        {2'd1,1'b0,1'b1,1'b1,4'd0,1'b1,2'd2,6'b111000,32'h0000_0000}, // R2
        {2'd2,1'b0,1'b1,1'b1,4'd3,1'b1,2'd2,6'b000110,32'h1000_0000}, // R8 no-execute
        {2'd0,1'b0,1'b1,1'b1,4'd3,1'b1,2'd2,6'b110000,32'h0000_0000}, // R4
        {2'd0,1'b0,1'b1,1'b1,4'd0,1'b0,2'd0,6'b000100,32'h4000_0000}, // R6 load
        {2'd1,1'b0,1'b1,1'b1,4'd0,1'b0,2'd0,6'b000100,32'h4200_0000}, // R6 store
        {2'd2,1'b0,1'b1,1'b1,4'd0,1'b0,2'd0,6'b000110,32'h4000_0000}, // R6 fetch
        {2'd2,1'b0,1'b0,1'b1,4'd3,1'b0,2'd0,6'b111001,32'h0000_0000}, // R5 real fetch
        {2'd1,1'b0,1'b1,1'b0,4'd1,1'b0,2'd0,6'b111001,32'h0000_0000}, // R5 real store
        {2'd2,1'b0,1'b1,1'b0,4'd0,1'b0,2'd0,6'b000110,32'h4000_0000}, // R5 fetch uses ixlate
        {2'd0,1'b0,1'b0,1'b1,4'd0,1'b0,2'd0,6'b000100,32'h4000_0000}, // R5 load uses dxlate
        {2'd2,1'b0,1'b1,1'b1,4'd4,1'b0,2'd0,6'b000110,32'h1000_0000}, // R8 direct-store fetch
        {2'd0,1'b0,1'b1,1'b1,4'd4,1'b0,2'd0,6'b100001,32'h0000_0000}, // R9 load key0
        {2'd1,1'b0,1'b1,1'b1,4'd4,1'b0,2'd0,6'b000100,32'h0A00_0000}, // R9 store key0
        {2'd1,1'b0,1'b1,1'b1,4'd5,1'b1,2'd3,6'b010001,32'h0000_0000}, // R9 store key1
        {2'd0,1'b0,1'b1,1'b1,4'd5,1'b0,2'd0,6'b000100,32'h0800_0000}, // R9 load key1
        {2'd3,1'b0,1'b1,1'b1,4'd0,1'b1,2'd3,6'b101000,32'h0000_0000}, // R5 code 3 as load
        {2'd0,1'b1,1'b1,1'b1,4'd1,1'b1,2'd3,6'b101000,32'h0000_0000}, // R3 user
        {2'd3,1'b0,1'b1,1'b0,4'd0,1'b0,2'd0,6'b111001,32'h0000_0000}  // R5 code 3 uses dxlate
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic [1:0]      req_access;
    logic            req_user;
    logic            req_ixlate;
    logic            req_dxlate;
    logic [AW-1:0]   req_ea;
    logic            req_hit;
    logic [1:0]      req_pp;
    logic [63:0]     seg_attr;
    logic            rsp_valid, rsp_rd, rsp_wr, rsp_ex;
    logic            rsp_fault, rsp_fault_instr, rsp_bypass;
    logic [31:0]     rsp_status;
    logic [AW-1:0]   rsp_far;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_perm_classifier u_seg_perm_classifier (
        .clk, .rst_n, .req_valid, .req_access, .req_user, .req_ixlate,
        .req_dxlate, .req_ea, .req_hit, .req_pp, .seg_attr,
        .rsp_valid, .rsp_rd, .rsp_wr, .rsp_ex, .rsp_fault,
        .rsp_fault_instr, .rsp_bypass, .rsp_status, .rsp_far
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic [AW-1:0] ea);
        req_access = v.acc;
        req_user   = v.usr;
        req_ixlate = v.ix;
        req_dxlate = v.dx;
        req_ea     = ea;
        req_hit    = v.hit;
        req_pp     = v.pp;
    endtask

    function automatic logic [5:0] out_flags();
        return {rsp_rd, rsp_wr, rsp_ex, rsp_fault, rsp_fault_instr, rsp_bypass};
    endfunction

    initial begin
        // R1 attribute nibbles: bit0 user key, bit1 supervisor key, bit2 no-exec, bit3 direct-store
        seg_attr = '0;
        seg_attr[1*4 +: 4] = 4'b0011;
        seg_attr[2*4 +: 4] = 4'b0001;
        seg_attr[3*4 +: 4] = 4'b0100;
        seg_attr[4*4 +: 4] = 4'b1000;
        seg_attr[5*4 +: 4] = 4'b1011;
        seg_attr[6*4 +: 4] = 4'b0010;
        rst_n = 1'b0;
        req_valid = 1'b0;
        drive('0, '0);
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset valid", 64'(rsp_valid), 64'd0);
        check("R11 reset flags", 64'(out_flags()), 64'd0);
        check("R11 reset status", 64'(rsp_status), 64'd0);
        check("R11 reset far", 64'(rsp_far), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            logic [AW-1:0] ea;
            v  = vec_t'(VECS[i]);
            ea = {v.seg, 28'(i * 28'h01234A7 + 28'h0000_5A3)};
            drive(v, ea);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R11 vec %0d valid", i), 64'(rsp_valid), 64'd1);
            check($sformatf("vec %0d flags (table tags)", i), 64'(out_flags()), 64'(v.flags));
            check($sformatf("vec %0d status (table tags)", i), 64'(rsp_status), 64'(v.status));
            check($sformatf("R10 vec %0d far", i), 64'(rsp_far),
                  (v.flags[2] && !v.flags[1]) ? 64'(ea) : 64'd0);
        end

        // R11 hold with no request, while inputs change
        drive(vec_t'(VECS[15]), 32'h0ABC_0010);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        drive(vec_t'(VECS[0]), 32'h0000_0000);
        @(negedge clk);
        check("R11 idle valid low", 64'(rsp_valid), 64'd0);
        check("R11 idle status held", 64'(rsp_status), 64'h4200_0000);
        check("R11 idle far held", 64'(rsp_far), 64'h0ABC_0010);
        check("R11 idle flags held", 64'(out_flags()), 64'b000100);

        // R10 instruction fault leaves far at zero even right after a data fault
        drive(vec_t'(VECS[16]), 32'h0123_4567);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 fetch fault far zero", 64'(rsp_far), 64'd0);
        check("R10 fetch fault class", 64'(rsp_fault_instr), 64'd1);

        // R1 top address bits select: same low bits, segment 2 vs segment 0 for user load pp0
        drive(vec_t'(VECS[6]), 32'h0FFF_FFFF);
        req_user = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 seg0 user pp0 passes", 64'(rsp_fault), 64'd0);
        drive(vec_t'(VECS[6]), 32'h2FFF_FFFF);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 seg2 user pp0 faults", 64'(rsp_status), 64'h0800_0000);

        // R11 back-to-back requests each produce a result
        drive(vec_t'(VECS[14]), 32'h0000_1000);
        req_valid = 1'b1;
        @(negedge clk);
        check("R11 b2b first", 64'(rsp_status), 64'h4000_0000);
        drive(vec_t'(VECS[4]), 32'h1000_2000);
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 b2b second", 64'(out_flags()), 64'b111000);
        check("R11 b2b valid", 64'(rsp_valid), 64'd1);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule